// File: doc/BRIEF.md
# Boot Mode Unlock Guard

This block keeps a privileged boot mode switched off until software proves it means to enter it. Software writes bytes to a trigger register. Only an unbroken run of eight writes carrying a fixed key, in a fixed order, turns the mode on. A single enable bit would be too easy to set by accident, so a stray or runaway write cannot open the mode.

Once the mode is on, the level output `boot_en` stays high. Logic elsewhere uses it to gate its privileged paths, for example byte transfers to a serial flash. Software leaves the mode by writing a control register with its exit bit set. Each change of mode also gives a one-cycle pulse, so that downstream logic can start or tear down its own state.

Top module: `boot_unlock_guard`

## Requirements
- R1: While reset is asserted, and in the cycles after its release, `boot_en`, `boot_trig` and `boot_exit` are low and match progress is empty.
- R2: `boot_en` goes high only after eight consecutive trigger writes carrying the bytes 0xDE, 0xAD, 0xBE, 0xEF, 0xCA, 0xFE, 0xBA, 0xBE in that order. It rises in the cycle after the clock edge that samples the eighth write, and it stays high until an exit command.
- R3: A trigger write whose byte differs from the next expected byte discards the progress made so far. If that byte is 0xDE, it counts as the first byte of a new attempt. Otherwise matching restarts from nothing.
- R4: `boot_trig` is high for exactly one cycle, and that cycle is the first cycle of `boot_en` high. Completing the key again while the mode is already on gives no pulse, and the mode stays on.
- R5: A control write with bit 0 of `ctl_data` set clears `boot_en` in the next cycle. If the mode was on, `boot_exit` is high for that one cycle; if it was off, there is no pulse. When an exit command and the final key byte arrive in the same cycle, the exit wins.
- R6: Cycles with no trigger write leave match progress unchanged. This includes idle cycles and control writes with or without the exit bit.
- R7: After the key completes, progress restarts from the first byte. Repeating only the last seven bytes does not enter the mode again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_wr | input | 1 | Write strobe for the trigger register |
| trig_data | input | 8 | Byte written to the trigger register |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_data | input | 8 | Control word; bit 0 is the exit command |
| boot_en | output | 1 | Boot mode is active |
| boot_trig | output | 1 | One-cycle pulse on entry to boot mode |
| boot_exit | output | 1 | One-cycle pulse on leaving boot mode |

## Verification
The hardest condition to reach from the ports is an entry after a near miss. A run breaks partway, or breaks on 0xDE, and must then go on to full entry while control writes and idle cycles are mixed in. Uniform random bytes almost never produce eight key bytes in a row. The random stimulus is therefore biased: about half of the trigger writes carry the byte the bench model expects next, and some carry 0xDE. Directed cases cover the remaining corners: a break at the seventh byte, a repeated 0xDE, completing the key while the mode is already on, and an exit that arrives in the same cycle as the final byte.

// File: rtl/boot_unlock_pkg.sv
package boot_unlock_pkg;

  localparam int unsigned KEY_LEN  = 8;
  localparam int unsigned KEY_BITS = 8;

  // First key byte sits in the most significant position.
  localparam logic [KEY_LEN*KEY_BITS-1:0] UNLOCK_KEY = 64'hDEAD_BEEF_CAFE_BABE;

  typedef enum logic {
    MODE_LOCKED = 1'b0,
    MODE_OPEN   = 1'b1
  } boot_mode_e;

endpackage

// File: rtl/bug_rst_sync.sv
module bug_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bug_seq_matcher.sv
module bug_seq_matcher #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEQ_LEN = 8,
  parameter logic [SEQ_LEN*DATA_W-1:0] KEY = boot_unlock_pkg::UNLOCK_KEY,
  localparam int unsigned IDX_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              seq_done,
  output logic [IDX_W-1:0]  idx_o
);

  logic [DATA_W-1:0] key_arr [SEQ_LEN];
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_d;
  logic              hit_cur;
  logic              hit_first;
  logic              at_last;

  // Unpack the key; entry 0 is the first byte expected.
  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_key
    assign key_arr[g] = KEY[(SEQ_LEN-1-g)*DATA_W +: DATA_W];
  end

  assign hit_cur   = (wr_data == key_arr[idx_q]);
  assign hit_first = (wr_data == key_arr[0]);
  assign at_last   = (idx_q == IDX_W'(SEQ_LEN-1));

  always_comb begin
    idx_d    = idx_q;
    seq_done = 1'b0;
    if (wr_en) begin
      if (hit_cur) begin
        if (at_last) begin
          idx_d    = '0;
          seq_done = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else if (hit_first) begin
        idx_d = IDX_W'(1);
      end else begin
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (wr_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/bug_mode_ctrl.sv
module bug_mode_ctrl
  import boot_unlock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic leave_req,
  output logic mode_on,
  output logic enter_pulse,
  output logic leave_pulse
);

  boot_mode_e state_q;
  boot_mode_e state_d;
  logic       enter_d;
  logic       leave_d;
  logic       enter_q;
  logic       leave_q;

  always_comb begin
    state_d = state_q;
    if (leave_req) begin
      state_d = MODE_LOCKED;
    end else if (enter_req) begin
      state_d = MODE_OPEN;
    end
    enter_d = (state_q == MODE_LOCKED) && (state_d == MODE_OPEN);
    leave_d = (state_q == MODE_OPEN) && (state_d == MODE_LOCKED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_LOCKED;
      enter_q <= 1'b0;
      leave_q <= 1'b0;
    end else begin
      state_q <= state_d;
      enter_q <= enter_d;
      leave_q <= leave_d;
    end
  end

  assign mode_on     = (state_q == MODE_OPEN);
  assign enter_pulse = enter_q;
  assign leave_pulse = leave_q;

endmodule

// File: rtl/boot_unlock_guard.sv
module boot_unlock_guard #(
  parameter int unsigned DATA_W    = boot_unlock_pkg::KEY_BITS,
  parameter int unsigned SEQ_LEN   = boot_unlock_pkg::KEY_LEN,
  parameter logic [SEQ_LEN*DATA_W-1:0] KEY = boot_unlock_pkg::UNLOCK_KEY,
  parameter int unsigned CTL_W     = 8,
  parameter int unsigned EXIT_BIT  = 0,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_wr,
  input  logic [DATA_W-1:0] trig_data,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_data,
  output logic              boot_en,
  output logic              boot_trig,
  output logic              boot_exit
);

  localparam int unsigned IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;

  logic             rst_sync_n;
  logic             seq_done;
  logic             exit_cmd;
  logic [IDX_W-1:0] match_idx;

  bug_rst_sync #(
    .STAGES(RST_STAGE)
  ) rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  bug_seq_matcher #(
    .DATA_W (DATA_W),
    .SEQ_LEN(SEQ_LEN),
    .KEY    (KEY)
  ) matcher_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (trig_wr),
    .wr_data (trig_data),
    .seq_done(seq_done),
    .idx_o   (match_idx)
  );

  assign exit_cmd = ctl_wr & ctl_data[EXIT_BIT];

  bug_mode_ctrl mode_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .enter_req  (seq_done),
    .leave_req  (exit_cmd),
    .mode_on    (boot_en),
    .enter_pulse(boot_trig),
    .leave_pulse(boot_exit)
  );

endmodule

// File: rtl/boot_unlock_guard_chk.sv
module boot_unlock_guard_chk #(
  parameter int unsigned SEQ_LEN  = 8,
  parameter int unsigned CTL_W    = 8,
  parameter int unsigned EXIT_BIT = 0,
  localparam int unsigned IDX_W   = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             trig_wr,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_data,
  input logic             boot_en,
  input logic             boot_trig,
  input logic             boot_exit,
  input logic [IDX_W-1:0] match_idx
);

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_idx <= IDX_W'(SEQ_LEN-1)); // R2

  AST_ENTRY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !trig_wr |=> !$rose(boot_en)); // R2

  AST_TRIG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(boot_en) |-> boot_trig); // R4

  AST_TRIG_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    boot_trig |-> (boot_en && !$past(boot_en))); // R4

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    boot_trig |=> !boot_trig); // R4

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_wr && ctl_data[EXIT_BIT]) |=> !boot_en); // R5

  AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    boot_exit |-> (!boot_en && $past(boot_en))); // R5

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !trig_wr |=> $stable(match_idx)); // R6

endmodule

bind boot_unlock_guard boot_unlock_guard_chk #(
  .SEQ_LEN (SEQ_LEN),
  .CTL_W   (CTL_W),
  .EXIT_BIT(EXIT_BIT)
) chk_i (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .trig_wr   (trig_wr),
  .ctl_wr    (ctl_wr),
  .ctl_data  (ctl_data),
  .boot_en   (boot_en),
  .boot_trig (boot_trig),
  .boot_exit (boot_exit),
  .match_idx (match_idx)
);

// File: tb/boot_unlock_guard_tb_top.sv
module boot_unlock_guard_tb_top;

  logic       clk;
  logic       rst_n;
  logic       trig_wr;
  logic [7:0] trig_data;
  logic       ctl_wr;
  logic [7:0] ctl_data;
  logic       boot_en;
  logic       boot_trig;
  logic       boot_exit;

  int checks;
  int errors;
  int m_idx;
  bit m_en;
  bit done_flag;

  localparam logic [7:0] KEYB [8] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF,
                                      8'hCA, 8'hFE, 8'hBA, 8'hBE};

  boot_unlock_guard dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_wr  (trig_wr),
    .trig_data(trig_data),
    .ctl_wr   (ctl_wr),
    .ctl_data (ctl_data),
    .boot_en  (boot_en),
    .boot_trig(boot_trig),
    .boot_exit(boot_exit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected index after one trigger write (R2, R3, R7).
  function automatic int next_idx(input int idx, input logic [7:0] d, output bit fin);
    fin = 1'b0;
    if (d == KEYB[idx]) begin
      if (idx == 7) begin
        fin = 1'b1;
        return 0;
      end
      return idx + 1;
    end
    return (d == KEYB[0]) ? 1 : 0;
  endfunction

  // Drive one cycle from a falling edge, compare at the next falling edge.
  task automatic step(input bit tw, input logic [7:0] td, input bit cw,
                      input logic [7:0] cd, input string req);
    bit fin;
    bit prev;
    bit ex;
    bit exp_trig;
    bit exp_exit;
    trig_wr   = tw;
    trig_data = td;
    ctl_wr    = cw;
    ctl_data  = cd;
    fin  = 1'b0;
    if (tw) m_idx = next_idx(m_idx, td, fin);
    prev = m_en;
    ex   = cw && cd[0];
    if (ex) m_en = 1'b0;
    else if (fin) m_en = 1'b1;
    exp_trig = !prev && m_en;
    exp_exit = prev && ex;
    @(negedge clk);
    check(req, "boot_en", int'(boot_en), int'(m_en));
    check(req, "boot_trig", int'(boot_trig), int'(exp_trig));
    check(req, "boot_exit", int'(boot_exit), int'(exp_exit));
  endtask

  task automatic wr(input logic [7:0] d, input string req);
    step(1'b1, d, 1'b0, 8'h00, req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 8'h00, 1'b0, 8'h00, req);
  endtask

  task automatic do_exit(input string req);
    step(1'b0, 8'h00, 1'b1, 8'h01, req);
  endtask

  task automatic key_from(input int first, input string req);
    for (int i = first; i < 8; i++) wr(KEYB[i], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned r;
    checks = 0; errors = 0; m_idx = 0; m_en = 1'b0;
    trig_wr = 1'b0; trig_data = '0; ctl_wr = 1'b0; ctl_data = '0;
    rst_n = 1'b0;
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1", "boot_en in reset", int'(boot_en), 0);
    check("R1", "boot_trig in reset", int'(boot_trig), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "boot_en after reset", int'(boot_en), 0);
    check("R1", "boot_exit after reset", int'(boot_exit), 0);

    // R1: reset leaves empty progress: tail of key alone does not enter
    key_from(1, "R1");
    // R2: plain entry
    key_from(0, "R2");
    check("R2", "entered", int'(boot_en), 1);
    // R4: completing again while active gives no pulse
    key_from(0, "R4");
    // R5: exit, then exit while inactive
    do_exit("R5");
    do_exit("R5");
    // R7: after completion progress restarts; last seven bytes only
    key_from(1, "R7");
    check("R7", "no re-entry", int'(boot_en), 0);
    // R3: break on the seventh byte
    for (int i = 0; i < 6; i++) wr(KEYB[i], "R3");
    wr(8'h00, "R3");
    wr(KEYB[7], "R3");
    check("R3", "broken run", int'(boot_en), 0);
    // R3: repeated DE counts as a new first byte
    wr(8'hDE, "R3");
    key_from(0, "R3");
    check("R3", "DE restart", int'(boot_en), 1);
    do_exit("R5");
    // R6: idle and control writes interleaved
    for (int i = 0; i < 4; i++) wr(KEYB[i], "R6");
    idle("R6");
    step(1'b0, 8'h00, 1'b1, 8'hFE, "R6");
    step(1'b0, 8'h00, 1'b1, 8'h01, "R6");
    idle("R6");
    key_from(4, "R6");
    check("R6", "entered across gaps", int'(boot_en), 1);
    do_exit("R5");
    // R5: exit in the same cycle as the final byte
    for (int i = 0; i < 7; i++) wr(KEYB[i], "R5");
    step(1'b1, KEYB[7], 1'b1, 8'h01, "R5");
    check("R5", "exit wins", int'(boot_en), 0);

    // Biased random phase
    for (int n = 0; n < 4000; n++) begin
      int unsigned sel;
      logic [7:0] d;
      sel = $urandom_range(99);
      if (sel < 55) d = KEYB[m_idx];
      else if (sel < 65) d = 8'hDE;
      else d = 8'($urandom);
      if (sel < 80)
        step(1'b1, d, 1'b0, 8'h00, "R2");
      else if (sel < 88)
        idle("R6");
      else if (sel < 93)
        step(1'b0, 8'h00, 1'b1, 8'($urandom) & 8'hFE, "R6");
      else if (sel < 97)
        step(1'b0, 8'h00, 1'b1, 8'($urandom) | 8'h01, "R5");
      else
        step(1'b1, d, 1'b1, 8'($urandom), "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule